// File: doc/BRIEF.md
# Sensor-Indexed Guardband Period Controller

This block chooses the clock period code for a multi-unit SIMD execution stage. Every functional unit reports quantized readings for process, aging, temperature and voltage. Each unit owns a lookup table that turns one such reading set into the shortest period the unit can run at safely. The block then registers the largest period among the units that matter. In fine mode those are the units the current instruction uses, and the result is re-evaluated for every valid instruction. In coarse mode one representative reading set is looked up in every table, and the result moves only when a kernel begins.

A configuration field limits which readings take part in the lookup. Any reading left out is replaced by its worst-case code, so one table entry covers every value of it. Each entry carries the timing-error-rate class it was computed for. When that class differs from the programmed target class, or the entry was never written, or the entry holds a code outside the legal range, the lookup returns the longest period. Software reloads the tables through a single write port.

Top module: `gbp_period_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, `period_code` is 24, the longest period.
- R2: `period_code` value k stands for a period of (k+1) x 0.2 ns, and the output never exceeds 24.
- R3: In fine mode (`cfg_coarse`=0), an edge with `instr_valid`=1 and a non-empty `fu_use` loads `period_code` with the maximum lookup result over the units whose `fu_use` bit is 1. Each unit is looked up with its own readings. Unused units have no effect. The new value appears after that edge.
- R4: In fine mode, an edge with `instr_valid`=0 or `fu_use`=0 leaves `period_code` unchanged.
- R5: In coarse mode, the representative readings are looked up in every unit's table and the maximum is loaded only on an edge with `kernel_start`=1. Instruction strobes are ignored.
- R6: `cfg_subset` selects the readings used: 0 uses process only, 1 uses process and aging, 2 adds temperature, and 3 uses all four. A reading left out is forced before the lookup to its worst case: aging 7, temperature 7, voltage 0.
- R7: An entry never written since reset resolves to 24.
- R8: An entry that holds a code of 25 or more resolves to 24.
- R9: An entry whose stored class tag differs from `cfg_class` resolves to 24. The class codes are 0 for zero error rate, 1 for low (0 to 33%), 2 for medium (33 to 66%) and 3 for high (above 66%).
- R10: A write with `wr_en`=1 stores `wr_code` and `wr_class` in the table of unit `wr_fu` at `wr_idx`. The index is laid out as process [10:9], aging [8:6], temperature [5:3] and voltage [2:0]. A lookup on the same edge sees the old contents, lookups from the next edge see the new ones, and the tables of the other units are untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_coarse | input | 1 | 1 selects kernel-granular coarse mode |
| cfg_subset | input | 2 | Selects the readings used in the lookup |
| cfg_class | input | 2 | Target timing-error-rate class |
| wr_en | input | 1 | Table write strobe |
| wr_fu | input | 1 | Unit whose table is written |
| wr_idx | input | 11 | Table index {process, aging, temperature, voltage} |
| wr_class | input | 2 | Class tag stored with the entry |
| wr_code | input | 5 | Period code stored with the entry |
| fu_p | input | 4 | Process codes, 2 bits per unit, unit 0 lowest |
| fu_a | input | 6 | Aging codes, 3 bits per unit |
| fu_t | input | 6 | Temperature codes, 3 bits per unit |
| fu_v | input | 6 | Voltage codes, 3 bits per unit |
| rep_p | input | 2 | Representative process code |
| rep_a | input | 3 | Representative aging code |
| rep_t | input | 3 | Representative temperature code |
| rep_v | input | 3 | Representative voltage code |
| instr_valid | input | 1 | Instruction present this cycle |
| fu_use | input | 2 | Units used by the current instruction |
| kernel_start | input | 1 | Kernel boundary strobe for coarse mode |
| period_code | output | 5 | Registered period code |

## Verification
The bench builds the block with its defaults: two functional units and the full 11-bit reading index, which makes 2048 entries per table. With two units every mask pattern can be reached, including the empty one and both single-unit masks. This lets the bench show that one unit's bad entry (out of range, never written or tagged with the wrong class) reaches the output only when that unit is used. The full index width also lets the subset tests show that different aging, temperature and voltage values all land on the same forced entry.

// File: rtl/gbp_pkg.sv
// Shared widths and types for the guardband period controller.
// Assumes fixed sensor quantization: process 2 bits, the others 3 bits.
package gbp_pkg;
    localparam int P_W     = 2;
    localparam int A_W     = 3;
    localparam int T_W     = 3;
    localparam int V_W     = 3;
    localparam int IDX_W   = P_W + A_W + T_W + V_W;
    localparam int PER_W   = 5;
    localparam int PER_MAX = 24;
    localparam int CLS_W   = 2;

    // Worst-case codes substituted for readings left out of the lookup.
    localparam logic [A_W-1:0] A_WORST = '1;
    localparam logic [T_W-1:0] T_WORST = '1;
    localparam logic [V_W-1:0] V_WORST = '0;

    typedef enum logic [1:0] {
        SUB_P   = 2'd0,
        SUB_PA  = 2'd1,
        SUB_PAT = 2'd2,
        SUB_ALL = 2'd3
    } subset_e;

    // Reading set; field order matches the table index layout.
    typedef struct packed {
        logic [P_W-1:0] p;
        logic [A_W-1:0] a;
        logic [T_W-1:0] t;
        logic [V_W-1:0] v;
    } sense_t;
endpackage

// File: rtl/gbp_index_mask.sv
// Replaces the readings left out by the subset selection with their
// worst-case codes. Purely combinational; assumes a legal subset code.
module gbp_index_mask
    import gbp_pkg::*;
(
    input  sense_t  raw,
    input  subset_e sel,
    output sense_t  idx
);
    // Force unselected readings to their worst case.
    always_comb begin
        idx = raw;
        if (sel == SUB_P)                      idx.a = A_WORST;
        if (sel == SUB_P || sel == SUB_PA)     idx.t = T_WORST;
        if (sel != SUB_ALL)                    idx.v = V_WORST;
    end
endmodule

// File: rtl/gbp_fu_lut.sv
// One unit's period table: a write port and one asynchronous read port.
// Returns the longest period for entries that are unwritten, tagged with
// another class, or out of range. Assumes the index is already masked.
module gbp_fu_lut
    import gbp_pkg::*;
#(
    parameter int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CLS_W-1:0] wr_class,
    input  logic [PER_W-1:0] wr_code,
    input  sense_t           rd_idx,
    input  logic [CLS_W-1:0] cls,
    output logic [PER_W-1:0] rd_code
);
    logic [PER_W-1:0] code_mem [DEPTH];
    logic [CLS_W-1:0] tag_mem  [DEPTH];
    logic [DEPTH-1:0] valid_q;

    // Entry storage, no reset needed on data.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            code_mem[wr_idx] <= wr_code;
            tag_mem[wr_idx]  <= wr_class;
        end
    end

    // Written-since-reset flags.
    always_ff @(posedge clk) begin
        if (!rst_n)     valid_q         <= '0;
        else if (wr_en) valid_q[wr_idx] <= 1'b1;
    end

    // Resolve the looked-up entry to a safe period code.
    always_comb begin
        if (!valid_q[rd_idx] || tag_mem[rd_idx] != cls ||
            code_mem[rd_idx] > PER_W'(PER_MAX))
            rd_code = PER_W'(PER_MAX);
        else
            rd_code = code_mem[rd_idx];
    end

    p_lut_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_code <= PER_W'(PER_MAX));
endmodule

// File: rtl/gbp_max_reduce.sv
// Maximum of the selected per-unit period codes. Output is zero when
// nothing is selected; the caller decides whether to load it.
module gbp_max_reduce
    import gbp_pkg::*;
#(
    parameter int N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N*PER_W-1:0] vals,
    input  logic [N-1:0]     sel,
    output logic [PER_W-1:0] max_code
);
    // Linear scan over the selected units.
    always_comb begin
        max_code = '0;
        for (int i = 0; i < N; i++) begin
            if (sel[i] && vals[i*PER_W +: PER_W] > max_code)
                max_code = vals[i*PER_W +: PER_W];
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_chk
        p_max_covers_r3: assert property (@(posedge clk) disable iff (!rst_n)
            sel[g] |-> max_code >= vals[g*PER_W +: PER_W]);
    end
endmodule

// File: rtl/gbp_period_ctrl.sv
// Guardband period controller top. Per unit it picks the reading set
// (own readings in fine mode, representative set in coarse mode), masks it
// by subset, looks it up, and registers the maximum over the relevant units.
// Assumes inputs are synchronous to clk.
module gbp_period_ctrl
    import gbp_pkg::*;
#(
    parameter int NUM_FU = 2,
    localparam int FU_W  = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_coarse,
    input  logic [1:0]            cfg_subset,
    input  logic [CLS_W-1:0]      cfg_class,
    input  logic                  wr_en,
    input  logic [FU_W-1:0]       wr_fu,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [CLS_W-1:0]      wr_class,
    input  logic [PER_W-1:0]      wr_code,
    input  logic [NUM_FU*P_W-1:0] fu_p,
    input  logic [NUM_FU*A_W-1:0] fu_a,
    input  logic [NUM_FU*T_W-1:0] fu_t,
    input  logic [NUM_FU*V_W-1:0] fu_v,
    input  logic [P_W-1:0]        rep_p,
    input  logic [A_W-1:0]        rep_a,
    input  logic [T_W-1:0]        rep_t,
    input  logic [V_W-1:0]        rep_v,
    input  logic                  instr_valid,
    input  logic [NUM_FU-1:0]     fu_use,
    input  logic                  kernel_start,
    output logic [PER_W-1:0]      period_code
);
    subset_e                sub;
    sense_t                 rep_s;
    logic [NUM_FU*PER_W-1:0] lut_codes;
    logic [NUM_FU-1:0]      red_sel;
    logic [PER_W-1:0]       red_max;
    logic                   load;

    assign sub   = subset_e'(cfg_subset);
    assign rep_s = {rep_p, rep_a, rep_t, rep_v};

    for (genvar g = 0; g < NUM_FU; g++) begin : g_fu
        sense_t own_s, pick_s, idx_s;
        logic   wr_here;

        assign own_s   = {fu_p[g*P_W +: P_W], fu_a[g*A_W +: A_W],
                          fu_t[g*T_W +: T_W], fu_v[g*V_W +: V_W]};
        assign pick_s  = cfg_coarse ? rep_s : own_s;
        assign wr_here = wr_en && (wr_fu == FU_W'(g));

        gbp_index_mask u_mask (
            .raw (pick_s),
            .sel (sub),
            .idx (idx_s)
        );

        gbp_fu_lut u_lut (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_here),
            .wr_idx   (wr_idx),
            .wr_class (wr_class),
            .wr_code  (wr_code),
            .rd_idx   (idx_s),
            .cls      (cfg_class),
            .rd_code  (lut_codes[g*PER_W +: PER_W])
        );
    end

    // Coarse mode reduces over every unit, fine mode over the used ones.
    assign red_sel = cfg_coarse ? {NUM_FU{1'b1}} : fu_use;
    assign load    = cfg_coarse ? kernel_start : (instr_valid && (|fu_use));

    gbp_max_reduce #(.N(NUM_FU)) u_max (
        .clk      (clk),
        .rst_n    (rst_n),
        .vals     (lut_codes),
        .sel      (red_sel),
        .max_code (red_max)
    );

    // Period output register.
    always_ff @(posedge clk) begin
        if (!rst_n)    period_code <= PER_W'(PER_MAX);
        else if (load) period_code <= red_max;
    end

    p_reset_value_r1: assert property (@(posedge clk)
        !rst_n |=> period_code == PER_W'(PER_MAX));
    p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        period_code <= PER_W'(PER_MAX));
    p_hold_fine_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_coarse && !(instr_valid && (|fu_use))) |=> $stable(period_code));
    p_hold_coarse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_coarse && !kernel_start) |=> $stable(period_code));
endmodule

// File: tb/gbp_period_ctrl_tb_top.sv
module gbp_period_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_coarse = 1'b0;
    logic [1:0]  cfg_subset = 2'd3;
    logic [1:0]  cfg_class = 2'd1;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_fu = '0;
    logic [10:0] wr_idx = '0;
    logic [1:0]  wr_class = '0;
    logic [4:0]  wr_code = '0;
    logic [3:0]  fu_p = '0;
    logic [5:0]  fu_a = '0, fu_t = '0, fu_v = '0;
    logic [1:0]  rep_p = '0;
    logic [2:0]  rep_a = '0, rep_t = '0, rep_v = '0;
    logic        instr_valid = 1'b0;
    logic [1:0]  fu_use = '0;
    logic        kernel_start = 1'b0;
    logic [4:0]  period_code;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    gbp_period_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_coarse(cfg_coarse),
        .cfg_subset(cfg_subset), .cfg_class(cfg_class),
        .wr_en(wr_en), .wr_fu(wr_fu), .wr_idx(wr_idx),
        .wr_class(wr_class), .wr_code(wr_code),
        .fu_p(fu_p), .fu_a(fu_a), .fu_t(fu_t), .fu_v(fu_v),
        .rep_p(rep_p), .rep_a(rep_a), .rep_t(rep_t), .rep_v(rep_v),
        .instr_valid(instr_valid), .fu_use(fu_use),
        .kernel_start(kernel_start), .period_code(period_code)
    );

    // Reading sets, index layout {p[10:9], a[8:6], t[5:3], v[2:0]}.
    localparam logic [10:0] IA = {2'd1, 3'd2, 3'd3, 3'd4};
    localparam logic [10:0] IB = {2'd0, 3'd0, 3'd0, 3'd0};
    localparam logic [10:0] IC = {2'd2, 3'd1, 3'd1, 3'd1};
    localparam logic [10:0] ID = {2'd3, 3'd7, 3'd7, 3'd0};

    // {valid, use[1:0], s0, s1, expected}
    localparam int NV = 13;
    localparam logic [29:0] VEC [NV] = '{
        {1'b1, 2'b01, IA, IB, 5'd10},  // R3 unit 0 only
        {1'b1, 2'b10, IA, IB, 5'd12},  // R3 unit 1 only
        {1'b1, 2'b11, IA, IA, 5'd10},  // R3 max of 10,7
        {1'b1, 2'b11, IB, IB, 5'd12},  // R3 max of 5,12
        {1'b1, 2'b10, IB, IA, 5'd7},   // R3
        {1'b1, 2'b01, IB, IC, 5'd5},   // R3 unused unit's bad entry ignored
        {1'b1, 2'b10, IB, IC, 5'd24},  // R8 stored 30
        {1'b1, 2'b01, IC, IB, 5'd24},  // R7 unwritten
        {1'b1, 2'b01, IB, IA, 5'd5},   // R3 back down
        {1'b1, 2'b10, IB, ID, 5'd24},  // R9 tag 2 vs class 1
        {1'b1, 2'b01, ID, ID, 5'd9},   // R3
        {1'b1, 2'b00, IA, IA, 5'd9},   // R4 empty mask holds
        {1'b0, 2'b11, IA, IC, 5'd9}    // R4 no valid holds
    };

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: period_code=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_fu(input logic [10:0] s0, input logic [10:0] s1);
        fu_p = {s1[10:9], s0[10:9]};
        fu_a = {s1[8:6],  s0[8:6]};
        fu_t = {s1[5:3],  s0[5:3]};
        fu_v = {s1[2:0],  s0[2:0]};
    endtask

    task automatic set_rep(input logic [10:0] s);
        {rep_p, rep_a, rep_t, rep_v} = s;
    endtask

    task automatic wr(input logic f, input logic [10:0] idx, input logic [1:0] c, input logic [4:0] code);
        @(negedge clk);
        wr_en = 1'b1; wr_fu = f; wr_idx = idx; wr_class = c; wr_code = code;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // Drive one cycle of strobes, sample after the loading edge, clear strobes.
    task automatic step(input logic v, input logic [1:0] u, input logic [10:0] s0,
                        input logic [10:0] s1, input logic k);
        @(negedge clk);
        instr_valid = v; fu_use = u; set_fu(s0, s1); kernel_start = k;
        @(posedge clk); #1;
    endtask

    task automatic clr();
        instr_valid = 1'b0; fu_use = '0; kernel_start = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        check("R1 during reset", period_code, 5'd24);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after reset", period_code, 5'd24);

        wr(1'b0, IA, 2'd1, 5'd10);
        wr(1'b0, IB, 2'd1, 5'd5);
        wr(1'b0, ID, 2'd1, 5'd9);
        wr(1'b1, IA, 2'd1, 5'd7);
        wr(1'b1, IB, 2'd1, 5'd12);
        wr(1'b1, IC, 2'd1, 5'd30);
        wr(1'b1, ID, 2'd2, 5'd3);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][29], VEC[i][28:27], VEC[i][26:16], VEC[i][15:5], 1'b0);
            check($sformatf("R3/R4/R7/R8/R9 vector %0d", i), period_code, VEC[i][4:0]);
            if (i == 6) check("R2 output within range", (period_code > 5'd24) ? 5'd31 : 5'd0, 5'd0);
            clr();
        end

        // R6 subset forcing
        step(1'b1, 2'b01, IB, IB, 1'b0); clr();
        check("R3 set to 5", period_code, 5'd5);
        cfg_subset = 2'd0;
        step(1'b1, 2'b01, {2'd3, 3'd1, 3'd2, 3'd3}, IB, 1'b0); clr();
        check("R6 process only hits forced entry", period_code, 5'd9);
        cfg_subset = 2'd1;
        wr(1'b0, {2'd1, 3'd2, 3'd7, 3'd0}, 2'd1, 5'd14);
        step(1'b1, 2'b01, {2'd1, 3'd2, 3'd5, 3'd5}, IB, 1'b0); clr();
        check("R6 process+aging forced entry", period_code, 5'd14);
        cfg_subset = 2'd3;

        // R10 write visibility and isolation
        @(negedge clk);
        wr_en = 1'b1; wr_fu = 1'b0; wr_idx = IB; wr_class = 2'd1; wr_code = 5'd6;
        instr_valid = 1'b1; fu_use = 2'b01; set_fu(IB, IB);
        @(posedge clk); #1;
        check("R10 same-edge lookup sees old", period_code, 5'd5);
        wr_en = 1'b0;
        @(posedge clk); #1;
        check("R10 next-edge lookup sees new", period_code, 5'd6);
        clr();
        step(1'b1, 2'b10, IB, IB, 1'b0); clr();
        check("R10 other unit untouched", period_code, 5'd12);

        // R5 coarse mode
        cfg_coarse = 1'b1;
        set_rep(IA);
        step(1'b1, 2'b01, IB, IB, 1'b0); clr();
        check("R5 instruction ignored in coarse", period_code, 5'd12);
        step(1'b0, 2'b00, IB, IB, 1'b1); clr();
        check("R5 kernel start loads max of 10,7", period_code, 5'd10);
        set_rep(IB);
        step(1'b0, 2'b00, IA, IA, 1'b0); clr();
        check("R5 hold without kernel start", period_code, 5'd10);
        step(1'b0, 2'b00, IA, IA, 1'b1); clr();
        check("R5 kernel start loads max of 6,12", period_code, 5'd12);
        set_rep(IC);
        step(1'b0, 2'b00, IA, IA, 1'b1); clr();
        check("R5/R7 unwritten entry in coarse", period_code, 5'd24);

        // R9 class change
        cfg_coarse = 1'b0; cfg_class = 2'd2;
        step(1'b1, 2'b10, IA, ID, 1'b0); clr();
        check("R9 matching tag 2", period_code, 5'd3);
        step(1'b1, 2'b01, IA, ID, 1'b0); clr();
        check("R9 tag 1 vs class 2", period_code, 5'd24);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule